// File: doc/BRIEF.md
# Camera Frame Packer for a 32-bit Parallel Bridge Bus

This block sits between an image sensor port and a 32-bit synchronous parallel bus that feeds a USB bridge. The sensor side delivers one pixel per clock while both its frame and line strobes are high. Pixels are 8 or 16 bits deep, selected by a configuration input. The block packs pixels into 32-bit words with the earliest pixel in the least significant bits. It pads every line with a programmable fill value up to the next multiple of eight pixels, so a line never ends on a half-filled 8-byte boundary in the receiver's buffers. Each frame on the bus starts with eight header words.

The two sides are decoupled by a word FIFO. Entries in the FIFO are tagged as data words, frame-start markers or frame-end markers. While either of two downstream flow-control flags is high, the output side presents nothing new and the FIFO absorbs the sensor traffic. A sticky overflow bit records any word lost to a full FIFO. A test mode replaces each line word with a running count of the words already sent in the frame, and puts a fixed marker in the first word of each line, so that word loss and line slips can be seen at the receiver.

Interface assumptions: there are at least 8 idle clocks between the end of one line and the start of the next, and at least 1 idle clock between the frame strobe rising and the first pixel.

Top module: `cam_frame_packer`

## Requirements
- R1: While reset is applied and directly after it, `bus_lv`, `bus_fv` and `ovf_flag` are low.
- R2: Every frame on the bus starts with eight header words. Word i is `hdr_words[32*i+31:32*i]`, sampled when the block starts sending that frame, with word 0 first. The header is sent ahead of the first line word, and no words beyond the expected stream appear.
- R3: With `cfg_wide`=0 (8 bits per pixel), each word holds four pixels. The first pixel is in bits 7:0 and the fourth in bits 31:24. Pixel input bits 15:8 are ignored.
- R4: With `cfg_wide`=1 (16 bits per pixel), each word holds two pixels, the first in bits 15:0.
- R5: Every line is extended to the next multiple of eight pixels using `cfg_fill` (its low 8 bits in 8-bit mode). For example, 13 pixels become 16 and 1452 become 1456. A line that is already a multiple of eight gets no padding. Pad words are presented with `bus_lv` high, like pixel words.
- R6: After a clock edge at which `dma_flag_a` or `dma_flag_b` is high, no word is presented (`bus_lv` low). Once both flags are low again, the stream resumes with nothing lost or repeated.
- R7: With `cfg_test`=1, the first word of each line is 0xEEEEEEEE. Every other line word equals the number of words already presented in the frame, counting from 0 at the first header word. Header words are unchanged.
- R8: `bus_fv` is high whenever `bus_lv` is high. It is low again once the last word of a frame has been presented.
- R9: A word pushed while the FIFO holds 64 entries is dropped and sets `ovf_flag`. The flag then stays high until a cycle with `ovf_clr` high.
- R10: Lines of up to 1936 pixels and frames of up to 1096 lines are carried correctly, including the test-mode word count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| rst | input | 1 | Synchronous active-high reset |
| cam_fv | input | 1 | Sensor frame strobe |
| cam_lv | input | 1 | Sensor line strobe; one pixel per clock while high |
| cam_pix | input | 16 | Sensor pixel; bits 7:0 only in 8-bit mode |
| cfg_wide | input | 1 | 0: 8 bits per pixel, 1: 16 bits per pixel |
| cfg_test | input | 1 | Counter test pattern on line words |
| cfg_fill | input | 16 | Pixel value used for line padding |
| hdr_words | input | 256 | Eight 32-bit header words, word 0 in the low bits |
| dma_flag_a | input | 1 | Downstream flow-control flag, high = hold |
| dma_flag_b | input | 1 | Second downstream flow-control flag, high = hold |
| ovf_clr | input | 1 | Write-one-to-clear for the overflow flag |
| bus_data | output | 32 | Output word |
| bus_fv | output | 1 | Frame strobe on the output bus |
| bus_lv | output | 1 | Word strobe: a word is transferred in each cycle it is high |
| ovf_flag | output | 1 | Sticky FIFO overflow indication |

## Verification
The packing path is driven in 8-bit mode with widths that are and are not multiples of eight. It is also driven in 16-bit mode with a distinct fill value, so that a wrong lane order, a wrong pad count and a fill that leaks in as pixel data each give a different mismatch. The pixel stimulus sets the upper input bits in 8-bit mode, which exposes any use of bits that must be ignored. A long frame of short lines and a full-width frame in test mode separate counter wrap or width problems from alignment problems, and a bursty pattern on both flags checks that stalls neither drop nor repeat words. A final run holds the flags high through a long line to fill the FIFO and exercise the sticky overflow bit and its clear.

// File: rtl/cfp_pkg.sv
`timescale 1ns/1ps
package cfp_pkg;
    localparam int BUS_W     = 32;
    localparam int PIX_W     = 16;
    localparam int ALIGN_PIX = 8;
    localparam int ALIGN_W   = $clog2(ALIGN_PIX);
    localparam logic [BUS_W-1:0] LINE_MARK = 32'hEEEE_EEEE;

    typedef enum logic [1:0] {
        ENT_WORD = 2'd0,
        ENT_SOF  = 2'd1,
        ENT_EOF  = 2'd2
    } ent_kind_e;

    typedef struct packed {
        ent_kind_e         kind;
        logic              sol;
        logic [BUS_W-1:0]  data;
    } ent_t;

    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_HDR  = 2'd1,
        TX_RUN  = 2'd2
    } tx_state_e;

    function automatic logic [BUS_W-1:0] place_pixel(
        input logic [BUS_W-1:0] acc,
        input logic [PIX_W-1:0] pix,
        input logic             wide,
        input logic [1:0]       slot);
        logic [BUS_W-1:0] r;
        r = acc;
        if (wide) r[16*int'(slot[0]) +: 16] = pix;
        else      r[8*int'(slot) +: 8]      = pix[7:0];
        return r;
    endfunction
endpackage

// File: rtl/cfp_packer.sv
`timescale 1ns/1ps
module cfp_packer
    import cfp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cam_fv,
    input  logic             cam_lv,
    input  logic [PIX_W-1:0] cam_pix,
    input  logic             wide,
    input  logic [PIX_W-1:0] fill,
    output logic             push,
    output ent_t             push_ent
);
    logic               fv_q, lv_q, first_q, eof_pend;
    logic [1:0]         slot;
    logic [ALIGN_W-1:0] px_mod, pad_cnt;
    logic [BUS_W-1:0]   acc, acc_n;
    logic               line_on, fv_rise, fv_fall, lv_rise, lv_fall;
    logic               pad_on, pix_vld, last_slot, word_done, eof_go;
    logic [PIX_W-1:0]   pix_val;

    always_comb begin
        line_on   = cam_fv & cam_lv;
        fv_rise   = cam_fv & ~fv_q;
        fv_fall   = ~cam_fv & fv_q;
        lv_rise   = line_on & ~lv_q;
        lv_fall   = lv_q & ~line_on;
        pad_on    = (pad_cnt != '0);
        pix_vld   = line_on | pad_on;
        pix_val   = line_on ? cam_pix : fill;
        last_slot = wide ? (slot[0] == 1'b1) : (slot == 2'd3);
        word_done = pix_vld & last_slot;
        acc_n     = place_pixel(acc, pix_val, wide, slot);
        eof_go    = eof_pend & ~pad_on & ~lv_fall & ~word_done & ~line_on;
    end

    always_comb begin
        push          = 1'b0;
        push_ent.kind = ENT_WORD;
        push_ent.sol  = first_q;
        push_ent.data = acc_n;
        if (word_done) begin
            push = 1'b1;
        end else if (fv_rise) begin
            push          = 1'b1;
            push_ent.kind = ENT_SOF;
        end else if (eof_go) begin
            push          = 1'b1;
            push_ent.kind = ENT_EOF;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fv_q     <= 1'b0;
            lv_q     <= 1'b0;
            first_q  <= 1'b0;
            eof_pend <= 1'b0;
            slot     <= '0;
            px_mod   <= '0;
            pad_cnt  <= '0;
            acc      <= '0;
        end else begin
            fv_q <= cam_fv;
            lv_q <= line_on;
            if (fv_rise) begin
                slot     <= '0;
                px_mod   <= '0;
                pad_cnt  <= '0;
                eof_pend <= 1'b0;
            end else begin
                if (fv_fall)
                    eof_pend <= 1'b1;
                else if (eof_go)
                    eof_pend <= 1'b0;
                if (pix_vld) begin
                    acc    <= word_done ? '0 : acc_n;
                    slot   <= last_slot ? 2'd0 : slot + 2'd1;
                    px_mod <= px_mod + 1'b1;
                end
                if (lv_fall)
                    pad_cnt <= '0 - px_mod;
                else if (pad_on)
                    pad_cnt <= pad_cnt - 1'b1;
            end
            if (lv_rise)
                first_q <= 1'b1;
            else if (word_done)
                first_q <= 1'b0;
        end
    end
endmodule

// File: rtl/cfp_word_fifo.sv
`timescale 1ns/1ps
module cfp_word_fifo
    import cfp_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic push,
    input  ent_t wr_ent,
    input  logic pop,
    output ent_t head,
    output logic empty,
    output logic full
);
    localparam int AW = $clog2(DEPTH);

    ent_t          mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [AW:0]   cnt;
    logic          do_push, do_pop;

    always_comb begin
        empty   = (cnt == '0);
        full    = (cnt == (AW+1)'(DEPTH));
        do_push = push & ~full;
        do_pop  = pop & ~empty;
        head    = mem[rp];
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= wr_ent;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= wp + 1'b1;
            if (do_pop)  rp <= rp + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/cfp_bus_sender.sv
`timescale 1ns/1ps
module cfp_bus_sender
    import cfp_pkg::*;
#(
    parameter int NUM_HDR = 8,
    parameter int WCNT_W  = 21
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     stall,
    input  logic                     test,
    input  logic [NUM_HDR*BUS_W-1:0] hdr_in,
    input  ent_t                     head,
    input  logic                     empty,
    output logic                     pop,
    output logic [BUS_W-1:0]         bus_data,
    output logic                     bus_lv,
    output logic                     bus_fv
);
    localparam int IW = (NUM_HDR > 1) ? $clog2(NUM_HDR) : 1;

    tx_state_e                      state;
    logic [NUM_HDR-1:0][BUS_W-1:0]  hdr_q;
    logic [IW-1:0]                  idx;
    logic [WCNT_W-1:0]              wcnt;

    always_comb begin
        case (state)
            TX_IDLE: pop = ~empty;
            TX_RUN:  pop = ~empty & ((head.kind != ENT_WORD) | ~stall);
            default: pop = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= TX_IDLE;
            hdr_q    <= '0;
            idx      <= '0;
            wcnt     <= '0;
            bus_data <= '0;
            bus_lv   <= 1'b0;
            bus_fv   <= 1'b0;
        end else begin
            bus_lv <= 1'b0;
            case (state)
                TX_IDLE: begin
                    if (!empty && head.kind == ENT_SOF) begin
                        hdr_q <= hdr_in;
                        idx   <= '0;
                        wcnt  <= '0;
                        state <= TX_HDR;
                    end
                end
                TX_HDR: begin
                    if (!stall) begin
                        bus_data <= hdr_q[idx];
                        bus_lv   <= 1'b1;
                        bus_fv   <= 1'b1;
                        wcnt     <= wcnt + 1'b1;
                        idx      <= idx + 1'b1;
                        if (idx == IW'(NUM_HDR-1)) state <= TX_RUN;
                    end
                end
                TX_RUN: begin
                    if (!empty) begin
                        case (head.kind)
                            ENT_WORD: begin
                                if (!stall) begin
                                    if (test)
                                        bus_data <= head.sol ? LINE_MARK : BUS_W'(wcnt);
                                    else
                                        bus_data <= head.data;
                                    bus_lv <= 1'b1;
                                    wcnt   <= wcnt + 1'b1;
                                end
                            end
                            ENT_EOF: begin
                                bus_fv <= 1'b0;
                                state  <= TX_IDLE;
                            end
                            default: begin
                                hdr_q <= hdr_in;
                                idx   <= '0;
                                wcnt  <= '0;
                                state <= TX_HDR;
                            end
                        endcase
                    end
                end
                default: state <= TX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cam_frame_packer.sv
`timescale 1ns/1ps
module cam_frame_packer
    import cfp_pkg::*;
#(
    parameter int NUM_HDR    = 8,
    parameter int FIFO_DEPTH = 64,
    parameter int MAX_WIDTH  = 1936,
    parameter int MAX_LINES  = 1096
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cam_fv,
    input  logic                     cam_lv,
    input  logic [PIX_W-1:0]         cam_pix,
    input  logic                     cfg_wide,
    input  logic                     cfg_test,
    input  logic [PIX_W-1:0]         cfg_fill,
    input  logic [NUM_HDR*BUS_W-1:0] hdr_words,
    input  logic                     dma_flag_a,
    input  logic                     dma_flag_b,
    input  logic                     ovf_clr,
    output logic [BUS_W-1:0]         bus_data,
    output logic                     bus_fv,
    output logic                     bus_lv,
    output logic                     ovf_flag
);
    localparam int LINE_WORDS = (MAX_WIDTH + ALIGN_PIX - 1) / ALIGN_PIX * ALIGN_PIX * PIX_W / BUS_W;
    localparam int WCNT_W     = $clog2(NUM_HDR + MAX_LINES * LINE_WORDS + 1);

    logic pk_push, fifo_full, fifo_empty, tx_pop, stall;
    ent_t pk_ent, fifo_head;

    assign stall = dma_flag_a | dma_flag_b;

    cfp_packer packer_i (
        .clk      (clk),
        .rst      (rst),
        .cam_fv   (cam_fv),
        .cam_lv   (cam_lv),
        .cam_pix  (cam_pix),
        .wide     (cfg_wide),
        .fill     (cfg_fill),
        .push     (pk_push),
        .push_ent (pk_ent)
    );

    cfp_word_fifo #(.DEPTH(FIFO_DEPTH)) fifo_i (
        .clk    (clk),
        .rst    (rst),
        .push   (pk_push),
        .wr_ent (pk_ent),
        .pop    (tx_pop),
        .head   (fifo_head),
        .empty  (fifo_empty),
        .full   (fifo_full)
    );

    cfp_bus_sender #(.NUM_HDR(NUM_HDR), .WCNT_W(WCNT_W)) sender_i (
        .clk      (clk),
        .rst      (rst),
        .stall    (stall),
        .test     (cfg_test),
        .hdr_in   (hdr_words),
        .head     (fifo_head),
        .empty    (fifo_empty),
        .pop      (tx_pop),
        .bus_data (bus_data),
        .bus_lv   (bus_lv),
        .bus_fv   (bus_fv)
    );

    always_ff @(posedge clk) begin
        if (rst) ovf_flag <= 1'b0;
        else     ovf_flag <= (ovf_flag & ~ovf_clr) | (pk_push & fifo_full);
    end
endmodule

// File: rtl/cfp_checker.sv
`timescale 1ns/1ps
module cfp_checker (
    input logic clk,
    input logic rst,
    input logic flag_a,
    input logic flag_b,
    input logic bus_lv,
    input logic bus_fv,
    input logic ovf,
    input logic ovf_clr,
    input logic fifo_full,
    input logic push
);
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!bus_lv && !bus_fv && !ovf));

    p_hold_on_flag_r6: assert property (@(posedge clk) disable iff (rst)
        (flag_a || flag_b) |=> !bus_lv);

    p_word_in_frame_r8: assert property (@(posedge clk) disable iff (rst)
        bus_lv |-> bus_fv);

    p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (ovf && !ovf_clr) |=> ovf);

    p_ovf_cause_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf) |-> $past(fifo_full && push));

    p_ovf_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (ovf_clr && !(fifo_full && push)) |=> !ovf);
endmodule

bind cam_frame_packer cfp_checker chk_i (
    .clk       (clk),
    .rst       (rst),
    .flag_a    (dma_flag_a),
    .flag_b    (dma_flag_b),
    .bus_lv    (bus_lv),
    .bus_fv    (bus_fv),
    .ovf       (ovf_flag),
    .ovf_clr   (ovf_clr),
    .fifo_full (fifo_full),
    .push      (pk_push)
);

// File: tb/cam_frame_packer_tb_top.sv
`timescale 1ns/1ps
module cam_frame_packer_tb_top;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cam_fv = 1'b0, cam_lv = 1'b0;
    logic [15:0]  cam_pix = '0;
    logic         cfg_wide = 1'b0, cfg_test = 1'b0;
    logic [15:0]  cfg_fill = '0;
    logic [255:0] hdr_words;
    logic         dma_flag_a = 1'b0, dma_flag_b = 1'b0, ovf_clr = 1'b0;
    logic [31:0]  bus_data;
    logic         bus_fv, bus_lv, ovf_flag;

    int errors = 0;
    int checks = 0;
    int flag_mode = 0;
    int cyc = 0;
    bit chk_en = 1'b1;
    logic stall_seen = 1'b0;
    logic [31:0] hdr_val [8];
    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #5 clk = ~clk;

    always_comb
        for (int i = 0; i < 8; i++) hdr_words[32*i +: 32] = hdr_val[i];

    cam_frame_packer dut_i (
        .clk(clk), .rst(rst), .cam_fv(cam_fv), .cam_lv(cam_lv), .cam_pix(cam_pix),
        .cfg_wide(cfg_wide), .cfg_test(cfg_test), .cfg_fill(cfg_fill),
        .hdr_words(hdr_words), .dma_flag_a(dma_flag_a), .dma_flag_b(dma_flag_b),
        .ovf_clr(ovf_clr), .bus_data(bus_data), .bus_fv(bus_fv), .bus_lv(bus_lv),
        .ovf_flag(ovf_flag)
    );

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] pixv(int l, int x, int seed);
        return 16'((l * 131 + x * 7 + seed * 29) ^ 32'hA5C3);
    endfunction

    always @(posedge clk) stall_seen <= dma_flag_a | dma_flag_b;

    always @(negedge clk) begin
        cyc <= cyc + 1;
        case (flag_mode)
            1: begin
                dma_flag_a <= (cyc % 7) < 3;
                dma_flag_b <= (cyc % 11) == 0;
            end
            2: begin
                dma_flag_a <= 1'b1;
                dma_flag_b <= 1'b0;
            end
            default: begin
                dma_flag_a <= 1'b0;
                dma_flag_b <= 1'b0;
            end
        endcase
    end

    // per-clock comparison against the reference stream
    always @(negedge clk) begin
        logic [31:0] e;
        string t;
        if (!rst) begin
            if (stall_seen) check(!bus_lv, "R6 word after flag", 32'(bus_lv), 32'h0);
            if (bus_lv && chk_en) begin
                check(bus_fv, "R8 fv with word", 32'(bus_fv), 32'h1);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2 unexpected extra word", bus_data, 32'h0);
                end else begin
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(bus_data === e, t, bus_data, e);
                end
            end
        end
    end

    task automatic run_frame(int w, int h, bit wide, bit test, logic [15:0] fill, int seed);
        int k = 0;
        int ppw = wide ? 2 : 4;
        int wpad = ((w + 7) / 8) * 8;
        @(negedge clk);
        cfg_wide = wide;
        cfg_test = test;
        cfg_fill = fill;
        for (int i = 0; i < 8; i++) begin
            hdr_val[i] = {8'(seed), 8'(i), 16'hC0DE};
            exp_q.push_back(hdr_val[i]);
            tag_q.push_back("R2 header word");
            k++;
        end
        for (int l = 0; l < h; l++) begin
            for (int wd = 0; wd < wpad / ppw; wd++) begin
                logic [31:0] word = '0;
                string tg;
                for (int s = 0; s < ppw; s++) begin
                    int x = wd * ppw + s;
                    logic [15:0] v = (x < w) ? pixv(l, x, seed) : fill;
                    if (wide) word[16*s +: 16] = v;
                    else      word[8*s +: 8]   = v[7:0];
                end
                if (test) begin
                    word = (wd == 0) ? 32'hEEEE_EEEE : 32'(k);
                    tg = (h > 100 || w > 1000) ? "R10 test count" : "R7 test word";
                end else if ((wd + 1) * ppw > w) tg = "R5 padded word";
                else if (w > 1000) tg = "R10 wide line";
                else tg = wide ? "R4 packed word" : "R3 packed word";
                exp_q.push_back(word);
                tag_q.push_back(tg);
                k++;
            end
        end
        cam_fv = 1'b1;
        repeat (3) @(negedge clk);
        for (int l = 0; l < h; l++) begin
            for (int x = 0; x < w; x++) begin
                cam_lv = 1'b1;
                cam_pix = pixv(l, x, seed);
                @(negedge clk);
            end
            cam_lv = 1'b0;
            repeat (12) @(negedge clk);
        end
        cam_fv = 1'b0;
        for (int n = 0; n < 20000 && exp_q.size() != 0; n++) @(negedge clk);
        repeat (6) @(negedge clk);
        check(exp_q.size() == 0, "R2 all words delivered", 32'(exp_q.size()), 32'h0);
        check(bus_fv == 1'b0, "R8 fv low after frame", 32'(bus_fv), 32'h0);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) hdr_val[i] = '0;
        repeat (4) @(negedge clk);
        check(!bus_lv && !bus_fv && !ovf_flag, "R1 outputs during reset",
              {29'h0, bus_lv, bus_fv, ovf_flag}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        check(!bus_lv && !bus_fv && !ovf_flag, "R1 outputs after reset",
              {29'h0, bus_lv, bus_fv, ovf_flag}, 32'h0);

        run_frame(16, 3, 1'b0, 1'b0, 16'h0000, 1);     // R3 aligned 8-bit
        run_frame(13, 4, 1'b0, 1'b0, 16'h125A, 2);     // R5 8-bit padding
        run_frame(10, 3, 1'b1, 1'b0, 16'hBEEF, 3);     // R4 R5 16-bit
        run_frame(20, 3, 1'b0, 1'b1, 16'h0000, 4);     // R7 test mode
        flag_mode = 1;
        run_frame(100, 5, 1'b0, 1'b0, 16'h0011, 5);    // R6 bursty flags
        flag_mode = 0;
        run_frame(1452, 2, 1'b0, 1'b0, 16'h0077, 6);   // R5 1452 -> 1456
        run_frame(1936, 2, 1'b1, 1'b1, 16'h0000, 7);   // R10 full width
        run_frame(12, 1096, 1'b1, 1'b1, 16'h0000, 8);  // R10 full height

        // R9 overflow: hold flow control and overrun the FIFO
        chk_en = 1'b0;
        flag_mode = 2;
        @(negedge clk);
        cfg_wide = 1'b1;
        cam_fv = 1'b1;
        repeat (3) @(negedge clk);
        for (int x = 0; x < 200; x++) begin
            cam_lv = 1'b1;
            cam_pix = 16'(x);
            @(negedge clk);
        end
        cam_lv = 1'b0;
        repeat (12) @(negedge clk);
        cam_fv = 1'b0;
        @(negedge clk);
        check(ovf_flag == 1'b1, "R9 overflow set", 32'(ovf_flag), 32'h1);
        repeat (10) @(negedge clk);
        check(ovf_flag == 1'b1, "R9 overflow sticky", 32'(ovf_flag), 32'h1);
        ovf_clr = 1'b1;
        @(negedge clk);
        ovf_clr = 1'b0;
        check(ovf_flag == 1'b0, "R9 overflow cleared", 32'(ovf_flag), 32'h0);

        rst = 1'b1;
        flag_mode = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        exp_q.delete();
        tag_q.delete();
        chk_en = 1'b1;
        @(negedge clk);
        check(!bus_lv && !bus_fv && !ovf_flag, "R1 outputs after second reset",
              {29'h0, bus_lv, bus_fv, ovf_flag}, 32'h0);
        run_frame(24, 2, 1'b0, 1'b0, 16'h0000, 9);     // R3 recovery

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule